// File: doc/BRIEF.md
# Gated Random Stall Pulse Generator

This block sits in the fabric next to a coprocessor. It issues single-cycle stall pulses at pseudo-random moments so that the coprocessor's externally visible timing varies from run to run. A 16-bit Galois shift register runs freely on every clock. In each cycle its low byte is compared against a programmable rate threshold, and a hit produces a pulse. The average stall rate therefore scales with the threshold, at roughly `rate_i / 256` of cycles before the spacing rule below thins the pulses.

An enable gate keeps the output low while the system is still settling. No pulse may appear until reset has been released for three clock edges and the clock-lock indicator has been sampled high on three consecutive edges. If the lock indicator drops, the gate closes at once and stays closed until three new consecutive locked edges have passed.

The block has no data path. All of its pins are plain control and status lines with no handshake. The single output is meant to be wired directly to the stall input of the coprocessor.

Top module: `stall_pulse_gen`

## Requirements
- R1: Reset is synchronous and active low. An edge that samples `rst_ni` low drives `stall_o` low and reloads the shift register with the seed 16'hACE1.
- R2: Every stall pulse lasts exactly one cycle. `stall_o` is never high after two consecutive edges.
- R3: `stall_o` can be high after edge n only if `rst_ni` was sampled high at edges n-3, n-2, n-1 and n. The first pulse after reset release can therefore follow the fourth edge at the earliest.
- R4: `stall_o` can be high after edge n only if `lock_i` was sampled high at edges n-3, n-2 and n-1. Any edge that samples `lock_i` low restarts this three-edge count.
- R5: The shift register is a right-shifting Galois register with feedback mask 16'hB400. On each step, if bit 0 is 1, the state becomes (state >> 1) ^ 16'hB400; otherwise it becomes state >> 1. It steps at every edge that samples `rst_ni` high, whatever the values of the other inputs, and its state is never zero.
- R6: After edge n, `stall_o` is 1 exactly when all of the following hold: the gate of R3 and R4 is open, the low 8 bits of the register state held before edge n are unsigned-less-than the `rate_i` value sampled at edge n, and `stall_o` was 0 before edge n.
- R7: A `rate_i` of 0 produces no pulses. A larger `rate_i` produces more pulses over the same stretch of register states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_ni | input | 1 | Synchronous active-low reset |
| lock_i | input | 1 | Clock-lock status; high means locked |
| rate_i | input | 8 | Stall rate threshold; 0 disables stalls |
| stall_o | output | 1 | Single-cycle stall pulse |

## Verification
The embedded assertions check four properties on every cycle:
- no two consecutive pulses occur;
- no pulse follows a cycle in which the gate was closed or the sampled rate was zero;
- the gate closes on the edge after lock is lost;
- the register state is never zero.

Three behaviours can only be shown by the bench's scenarios:
- the exact three-edge wait after reset release and after lock is regained;
- the seed reload on a mid-run reset;
- the pulse-for-pulse sequence that follows from the register polynomial and the threshold comparison, along with the growth in pulse count as the rate rises.

// File: rtl/stall_pkg.sv
package stall_pkg;
  localparam int unsigned LFSR_W   = 16;
  localparam int unsigned RATE_W   = 8;
  localparam int unsigned HOLD_CYC = 3;
  localparam logic [LFSR_W-1:0] FB_MASK = 16'hB400;
  localparam logic [LFSR_W-1:0] SEED    = 16'hACE1;
endpackage

// File: rtl/stall_lfsr.sv
module stall_lfsr #(
  parameter int unsigned W      = stall_pkg::LFSR_W,
  parameter int unsigned OUT_W  = stall_pkg::RATE_W,
  parameter logic [W-1:0] MASK  = stall_pkg::FB_MASK,
  parameter logic [W-1:0] SEED  = stall_pkg::SEED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [OUT_W-1:0] sample_o
);
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;

  always_comb begin
    state_d = state_q >> 1;
    if (state_q[0]) state_d = state_d ^ MASK;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= state_d;
  end

  assign sample_o = state_q[OUT_W-1:0];

  assert_state_nonzero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/stall_arm_gate.sv
module stall_arm_gate #(
  parameter int unsigned HOLD = stall_pkg::HOLD_CYC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lock_i,
  output logic armed_o
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] TOP = CW'(HOLD);

  logic [CW-1:0] rst_cnt_q;
  logic [CW-1:0] lock_cnt_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      rst_cnt_q  <= '0;
      lock_cnt_q <= '0;
    end else begin
      if (rst_cnt_q != TOP) rst_cnt_q <= rst_cnt_q + 1'b1;
      if (!lock_i)               lock_cnt_q <= '0;
      else if (lock_cnt_q != TOP) lock_cnt_q <= lock_cnt_q + 1'b1;
    end
  end

  assign armed_o = (rst_cnt_q == TOP) && (lock_cnt_q == TOP);

  assert_lock_loss_closes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_i |=> !armed_o);
endmodule

// File: rtl/stall_shaper.sv
module stall_shaper #(
  parameter int unsigned RW = stall_pkg::RATE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          armed_i,
  input  logic [RW-1:0] sample_i,
  input  logic [RW-1:0] rate_i,
  output logic          stall_o
);
  logic hit;
  logic stall_q;

  assign hit = armed_i && (sample_i < rate_i) && !stall_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) stall_q <= 1'b0;
    else         stall_q <= hit;
  end

  assign stall_o = stall_q;

  assert_single_cycle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);
  assert_gate_closed_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_i |=> !stall_o);
  assert_zero_rate_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == '0) |=> !stall_o);
endmodule

// File: rtl/stall_pulse_gen.sv
module stall_pulse_gen
  import stall_pkg::*;
#(
  parameter int unsigned RW   = RATE_W,
  parameter int unsigned HOLD = HOLD_CYC
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lock_i,
  input  logic [RW-1:0] rate_i,
  output logic          stall_o
);
  logic [RW-1:0] sample;
  logic          armed;

  stall_lfsr #(
    .W(LFSR_W), .OUT_W(RW), .MASK(FB_MASK), .SEED(SEED)
  ) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_o(sample)
  );

  stall_arm_gate #(.HOLD(HOLD)) u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .lock_i(lock_i), .armed_o(armed)
  );

  stall_shaper #(.RW(RW)) u_shaper (
    .clk_i(clk_i), .rst_ni(rst_ni), .armed_i(armed),
    .sample_i(sample), .rate_i(rate_i), .stall_o(stall_o)
  );

  assert_quiet_after_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> $past(rst_ni));
endmodule

// File: tb/stall_pulse_gen_tb.sv
`timescale 1ns/1ps
module stall_pulse_gen_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lock_i = 1'b0;
  logic [7:0] rate_i = 8'd0;
  logic       stall_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  stall_pulse_gen u_dut (.clk_i(clk), .rst_ni(rst_ni), .lock_i(lock_i),
                         .rate_i(rate_i), .stall_o(stall_o));

  // Reference model built from R1, R3-R6
  logic [15:0] m_st;
  int          m_rc, m_lc;
  logic        m_stall;
  always_ff @(posedge clk) begin
    if (!rst_ni) begin
      m_st <= 16'hACE1; m_rc <= 0; m_lc <= 0; m_stall <= 1'b0;
    end else begin
      m_stall <= (m_rc == 3) && (m_lc == 3) && (m_st[7:0] < rate_i) && !m_stall;
      m_st    <= m_st[0] ? ((m_st >> 1) ^ 16'hB400) : (m_st >> 1);
      if (m_rc < 3) m_rc <= m_rc + 1;
      m_lc <= lock_i ? ((m_lc < 3) ? m_lc + 1 : 3) : 0;
    end
  end

  logic prev_seen = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Wait for one edge, then compare at the falling edge. Returns the pulse seen.
  task automatic cyc(input string req, output bit s);
    @(negedge clk);
    s = stall_o;
    chk(stall_o === m_stall, req, stall_o, m_stall);
    if (rst_ni) chk(!(prev_seen && stall_o), "R2", stall_o, 0);
    prev_seen = stall_o;
  endtask

  task automatic do_reset();
    bit s;
    @(negedge clk); rst_ni = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(stall_o === 1'b0, "R1", stall_o, 0);
    end
    prev_seen = 1'b0;
    s = 1'b0;
  endtask

  task automatic t_startup();
    bit s; int early = 0;
    lock_i = 1'b1; rate_i = 8'hFF;
    do_reset();
    rst_ni = 1'b1;
    for (int i = 0; i < 3; i++) begin cyc("R3", s); if (s) early++; end
    chk(early == 0, "R3", early, 0);
    for (int i = 0; i < 200; i++) cyc("R6", s);
  endtask

  task automatic t_lock_late();
    bit s; int early = 0;
    lock_i = 1'b0; rate_i = 8'hFF;
    do_reset();
    rst_ni = 1'b1;
    for (int i = 0; i < 10; i++) begin cyc("R4", s); if (s) early++; end
    lock_i = 1'b1;
    for (int i = 0; i < 3; i++) begin cyc("R4", s); if (s) early++; end
    chk(early == 0, "R4", early, 0);
    for (int i = 0; i < 50; i++) cyc("R4", s);
  endtask

  task automatic t_lock_drop();
    bit s; int after = 0;
    rate_i = 8'hFF;
    for (int d = 0; d < 5; d++) begin
      lock_i = 1'b0;
      cyc("R4", s);
      lock_i = 1'b1;
      after = 0;
      for (int i = 0; i < 3; i++) begin cyc("R4", s); if (s) after++; end
      chk(after == 0, "R4", after, 0);
      for (int i = 0; i < 20 + d; i++) cyc("R4", s);
    end
  endtask

  task automatic t_rate_zero();
    bit s; int n = 0;
    rate_i = 8'd0; lock_i = 1'b1;
    cyc("R7", s);
    for (int i = 0; i < 1000; i++) begin cyc("R7", s); if (s) n++; end
    chk(n == 0, "R7", n, 0);
  endtask

  task automatic t_rate_sweep();
    bit s; int n_lo = 0, n_hi = 0;
    rate_i = 8'd16; lock_i = 1'b1;
    do_reset(); rst_ni = 1'b1;
    for (int i = 0; i < 2000; i++) begin cyc("R6", s); if (s) n_lo++; end
    rate_i = 8'd160;
    do_reset(); rst_ni = 1'b1;
    for (int i = 0; i < 2000; i++) begin cyc("R6", s); if (s) n_hi++; end
    chk(n_lo > 0, "R7", n_lo, 1);
    chk(n_hi > n_lo, "R7", n_hi, n_lo + 1);
  endtask

  task automatic t_reseed();
    bit s;
    rate_i = 8'd100; lock_i = 1'b1;
    for (int i = 0; i < 137; i++) cyc("R5", s);
    do_reset(); rst_ni = 1'b1;
    for (int i = 0; i < 500; i++) cyc("R1", s);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    t_startup();
    t_lock_late();
    t_lock_drop();
    t_rate_zero();
    t_rate_sweep();
    t_reseed();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end
endmodule